// File: doc/BRIEF.md
# Glitch-Free System Clock Source Switch

This block picks the system clock from three free-running, mutually asynchronous oscillator inputs: a main oscillator, a slow timer oscillator and an on-chip oscillator. A change of source never lets a shortened high or low phase reach the output. The outgoing clock is gated off on its own falling edges. The incoming clock is gated on only after the outgoing gate has been seen closed. The output therefore sits low for a short pause during every change.

Software controls the switch through one 8-bit control register in a separate register clock domain. The register holds a low-power idle choice, a 3-bit frequency choice for the on-chip oscillator and a 2-bit source select. It also reports two read-only status flags: main oscillator ready and on-chip oscillator stable. The idle choice and the frequency choice are only stored and exported. A source select written while a change is still under way is kept. It takes effect once the change in progress has finished.

Top module: `gcs_clk_switch`

## Requirements
- R1: While reset is held, and after it is released, `rd_data` reads 0x40 when both status inputs are low, `idle_en` is 0, `freq_sel` is 3'b100 and `sys_clk` stays low while reset is held.
- R2: A write with `wr_en` high stores bit 7 as the idle choice, bits 6:4 as the frequency choice and bits 1:0 as the source select. The new value is readable on `rd_data` in the cycle after the write, and `idle_en` and `freq_sel` mirror the stored fields.
- R3: Bits 3 and 2 of `rd_data` report `pri_ready` and `int_stable` respectively, visible within three `reg_clk` cycles of a change. Writes to those bit positions have no effect.
- R4: The source select decodes as 00 for `clk_pri`, 01 for `clk_tmr`, and 10 or 11 for `clk_int`. Once a switch has settled, `sys_clk` equals the selected input clock.
- R5: At no time are two source gates open together. The incoming gate opens only after the outgoing gate is closed.
- R6: Every high phase and every low phase of `sys_clk` lasts at least the shortest half period among the three inputs.
- R7: During a switch, the output low pause lasts at most two outgoing periods plus four incoming periods. Rewriting the select to a value with the same source causes no pause.
- R8: A select written while a switch is in progress is held. The source already being switched to is brought up fully before the held select is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register interface clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in every clock domain |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value including status flags |
| clk_pri | input | 1 | Main oscillator clock |
| clk_tmr | input | 1 | Slow timer oscillator clock |
| clk_int | input | 1 | On-chip oscillator clock |
| pri_ready | input | 1 | Main oscillator start-up wait expired (asynchronous) |
| int_stable | input | 1 | On-chip oscillator frequency settled (asynchronous) |
| sys_clk | output | 1 | Gated system clock |
| idle_en | output | 1 | Stored low-power idle choice |
| freq_sel | output | 3 | Stored on-chip oscillator frequency choice |

## Verification
The hardest state to reach is a second select write that lands while the gate of the previous target is still opening. The held value must then wait until the slow timer clock has been fully brought up. The bench writes the timer select and, two register cycles later, a different select. It then looks for a full 30 ns timer high phase on `sys_clk`, followed by a settled match on the last target. Random write bursts with short gaps also push many changes into switches still in flight. A pulse-width monitor watches `sys_clk` throughout.

// File: rtl/gcs_pkg.sv
`timescale 1ns/1ps
// Package: shared source encoding and select decode for the clock switch.
// Assumes exactly three clock sources with fixed roles.
package gcs_pkg;
    localparam int unsigned NUM_SRC = 3;
    localparam int unsigned SEL_W   = 2;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_TMR = 2'd1,
        SRC_INT = 2'd2
    } src_e;

    // Decode the 2-bit select field into a one-hot source vector.
    function automatic logic [NUM_SRC-1:0] sel_to_onehot(input logic [SEL_W-1:0] sel);
        logic [NUM_SRC-1:0] oh;
        oh = '0;
        if (sel[1])      oh[int'(SRC_INT)] = 1'b1;
        else if (sel[0]) oh[int'(SRC_TMR)] = 1'b1;
        else             oh[int'(SRC_PRI)] = 1'b1;
        return oh;
    endfunction
endpackage

// File: rtl/gcs_sync.sv
`timescale 1ns/1ps
// Module: multi-stage flop synchronizer for a bus of independent bits.
// Assumes each bit changes slowly enough to be treated on its own;
// it does not keep bits of the bus coherent with one another.
module gcs_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gcs_regs.sv
`timescale 1ns/1ps
// Module: 8-bit control register of the clock switch.
// Holds the idle choice, frequency choice and source select, and reports
// two status flags synchronized into reg_clk. Status bit positions are
// read-only; write data on them is discarded.
module gcs_regs #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned FREQ_W   = 3,
    parameter int unsigned SEL_W    = 2,
    parameter logic [2:0]  FREQ_RST = 3'b100
) (
    input  logic              reg_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pri_ready_async,
    input  logic              int_stable_async,
    output logic [DATA_W-1:0] rd_data,
    output logic              idle_en,
    output logic [FREQ_W-1:0] freq_sel,
    output logic [SEL_W-1:0]  sel_field
);
    localparam int unsigned IDLE_BIT = DATA_W - 1;
    localparam int unsigned FREQ_LO  = IDLE_BIT - FREQ_W;
    localparam int unsigned STAT_HI  = FREQ_LO - 1;
    localparam int unsigned STAT_LO  = SEL_W;

    logic [1:0] stat_sync;
    logic       unused_status_wr;

    gcs_sync #(.WIDTH(2), .STAGES(2)) u_stat_sync (
        .clk   (reg_clk),
        .rst_n (rst_n),
        .d     ({pri_ready_async, int_stable_async}),
        .q     (stat_sync)
    );

    // Load the writable fields on a register write.
    always_ff @(posedge reg_clk) begin
        if (!rst_n) begin
            idle_en   <= 1'b0;
            freq_sel  <= FREQ_RST;
            sel_field <= '0;
        end else if (wr_en) begin
            idle_en   <= wr_data[IDLE_BIT];
            freq_sel  <= wr_data[IDLE_BIT-1:FREQ_LO];
            sel_field <= wr_data[SEL_W-1:0];
        end
    end

    assign unused_status_wr = ^wr_data[STAT_HI:STAT_LO];
    assign rd_data = {idle_en, freq_sel, stat_sync, sel_field};

    // R1
    rst_val_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        $past(!rst_n) |-> (freq_sel == FREQ_RST && !idle_en && sel_field == '0));

    // R2
    sel_write_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        wr_en |=> (sel_field == $past(wr_data[SEL_W-1:0])));
endmodule

// File: rtl/gcs_arbiter.sv
`timescale 1ns/1ps
// Module: register-domain arbiter that picks which source gate may open.
// It changes its one-hot target only when the synchronized gate states
// match the current target, so a later select waits for a switch in flight.
module gcs_arbiter
    import gcs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               reg_clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel_field,
    input  logic [NUM_SRC-1:0] en_async,
    output logic [NUM_SRC-1:0] want_q
);
    localparam logic [NUM_SRC-1:0] WANT_RST = NUM_SRC'(1) << int'(SRC_PRI);

    logic [NUM_SRC-1:0] en_seen;
    logic [NUM_SRC-1:0] sel_oh;
    logic               settled;

    gcs_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_en_sync (
        .clk   (reg_clk),
        .rst_n (rst_n),
        .d     (en_async),
        .q     (en_seen)
    );

    assign sel_oh  = sel_to_onehot(sel_field);
    assign settled = (en_seen == want_q);

    // Advance the target only once the previous switch has completed.
    always_ff @(posedge reg_clk) begin
        if (!rst_n)                           want_q <= WANT_RST;
        else if (settled && sel_oh != want_q) want_q <= sel_oh;
    end

    // R8
    want_hold_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        !$stable(want_q) |-> ($past(en_seen) == $past(want_q)));

    // R4
    want_onehot_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        $countones(want_q) == 1);
endmodule

// File: rtl/gcs_branch.sv
`timescale 1ns/1ps
// Module: gate for one clock source.
// Assumes want and others_en are asynchronous to clk_src. Both pass
// through two falling-edge flops, so the gate only changes while clk_src
// is low and no partial pulse can leave the branch.
module gcs_branch (
    input  logic clk_src,
    input  logic rst_n,
    input  logic want,
    input  logic others_en,
    output logic en_q,
    output logic gated_clk
);
    logic arm_q;

    // Synchronize the open request, blocked while any other gate is open.
    always_ff @(negedge clk_src) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            arm_q <= want & ~others_en;
            en_q  <= arm_q;
        end
    end

    assign gated_clk = clk_src & en_q;
endmodule

// File: rtl/gcs_clk_switch.sv
`timescale 1ns/1ps
// Module: top of the glitch-free clock source switch.
// Builds one gate branch per source and ORs the gated clocks. Assumes all
// three input clocks keep running; a stopped outgoing clock would stall a switch.
module gcs_clk_switch
    import gcs_pkg::*;
(
    input  logic       reg_clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       clk_pri,
    input  logic       clk_tmr,
    input  logic       clk_int,
    input  logic       pri_ready,
    input  logic       int_stable,
    output logic       sys_clk,
    output logic       idle_en,
    output logic [2:0] freq_sel
);
    logic [SEL_W-1:0]   sel_field;
    logic [NUM_SRC-1:0] want_q;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] gated_vec;
    logic [NUM_SRC-1:0] others_vec;
    logic [NUM_SRC-1:0] src_clk_vec;

    assign src_clk_vec = {clk_int, clk_tmr, clk_pri};

    gcs_regs #(.DATA_W(8), .FREQ_W(3), .SEL_W(SEL_W), .FREQ_RST(3'b100)) u_regs (
        .reg_clk          (reg_clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .wr_data          (wr_data),
        .pri_ready_async  (pri_ready),
        .int_stable_async (int_stable),
        .rd_data          (rd_data),
        .idle_en          (idle_en),
        .freq_sel         (freq_sel),
        .sel_field        (sel_field)
    );

    gcs_arbiter #(.SYNC_STAGES(2)) u_arb (
        .reg_clk   (reg_clk),
        .rst_n     (rst_n),
        .sel_field (sel_field),
        .en_async  (en_vec),
        .want_q    (want_q)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_branch
        localparam logic [NUM_SRC-1:0] SELF_MASK = NUM_SRC'(1) << g;
        assign others_vec[g] = |(en_vec & ~SELF_MASK);
        gcs_branch u_branch (
            .clk_src   (src_clk_vec[g]),
            .rst_n     (rst_n),
            .want      (want_q[g]),
            .others_en (others_vec[g]),
            .en_q      (en_vec[g]),
            .gated_clk (gated_vec[g])
        );
    end

    assign sys_clk = |gated_vec;

    // R5
    single_src_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        $onehot0(en_vec));
endmodule

// File: tb/gcs_clk_switch_bench.sv
`timescale 1ns/1ps
module gcs_clk_switch_bench;
    logic       reg_clk = 0, clk_pri = 0, clk_tmr = 0, clk_int = 0;
    logic       rst_n = 0, wr_en = 0, pri_ready = 0, int_stable = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       sys_clk, idle_en;
    logic [2:0] freq_sel;

    int  n_chk = 0, n_fail = 0;
    bit  finished = 0;
    bit  mon_on = 0;
    real last_t = -1.0, min_hi = 1.0e9, min_lo = 1.0e9, max_hi = 0.0, max_lo = 0.0;

    always #5  reg_clk = ~reg_clk;
    always #7  clk_pri = ~clk_pri;
    always #30 clk_tmr = ~clk_tmr;
    always #11 clk_int = ~clk_int;

    gcs_clk_switch u_gcs_clk_switch (
        .reg_clk(reg_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .clk_pri(clk_pri), .clk_tmr(clk_tmr), .clk_int(clk_int),
        .pri_ready(pri_ready), .int_stable(int_stable), .sys_clk(sys_clk),
        .idle_en(idle_en), .freq_sel(freq_sel)
    );

    // Measure every high and low phase of the output clock.
    always @(sys_clk) begin
        if (mon_on) begin
            if (last_t >= 0.0) begin
                real dur;
                dur = $realtime - last_t;
                if (sys_clk == 1'b0) begin
                    if (dur < min_hi) min_hi = dur;
                    if (dur > max_hi) max_hi = dur;
                end else begin
                    if (dur < min_lo) min_lo = dur;
                    if (dur > max_lo) max_lo = dur;
                end
            end
            last_t = $realtime;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] d, input logic pr, input logic st);
        return {d[7:4], pr, st, d[1:0]};
    endfunction

    function automatic logic ref_clk(input logic [1:0] sel);
        if (sel[1])      return clk_int;
        else if (sel[0]) return clk_tmr;
        else             return clk_pri;
    endfunction

    task automatic reg_write(input logic [7:0] d);
        @(negedge reg_clk); wr_en = 1; wr_data = d;
        @(negedge reg_clk); wr_en = 0;
    endtask

    task automatic check_follow(input logic [1:0] sel, input string req);
        int bad = 0;
        #0.5;
        for (int k = 0; k < 40; k++) begin
            if (sys_clk !== ref_clk(sel)) bad++;
            #3.2;
        end
        check(bad == 0, req, "sys_clk mismatches vs selected source", bad, 0);
    endtask

    task automatic check_rd(input logic [7:0] exp, input string req);
        check(rd_data === exp, req, "rd_data", rd_data, exp);
        check(idle_en === exp[7] && freq_sel === exp[6:4], req, "idle_en/freq_sel",
              {idle_en, freq_sel}, exp[7:4]);
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] model;
        int bad;
        void'($urandom(32'd4711));
        // R1: output held low during reset, register reset value
        bad = 0;
        repeat (15) @(negedge reg_clk);
        for (int k = 0; k < 10; k++) begin
            #0.5; if (sys_clk !== 1'b0) bad++;
            @(negedge reg_clk);
        end
        check(bad == 0, "R1", "sys_clk high samples in reset", bad, 0);
        check_rd(8'h40, "R1");
        rst_n = 1; mon_on = 1;
        @(negedge reg_clk);
        check_rd(8'h40, "R1");
        #500;
        check_follow(2'b00, "R4");

        // R3: status bits ignore writes, then track inputs
        reg_write(8'h0C);
        check_rd(8'h00, "R3");
        pri_ready = 1;
        repeat (3) @(negedge reg_clk);
        check_rd(8'h08, "R3");
        int_stable = 1;
        repeat (3) @(negedge reg_clk);
        check_rd(8'h0C, "R3");
        reg_write(8'h00);
        check_rd(8'h0C, "R3");

        // R2: fields written, outputs mirror; select 01 picks timer (R4)
        reg_write(8'hB1);
        check_rd(8'hBD, "R2");
        #1500;
        check_follow(2'b01, "R4");

        // R7: pause bound on a main to on-chip switch
        reg_write(8'h40);
        #1500;
        check_follow(2'b00, "R4");
        max_lo = 0.0;
        reg_write(8'h42);
        #1500;
        check(max_lo <= 116.0 && max_lo >= 22.0, "R7", "switch pause ns",
              $rtoi(max_lo), 116);
        check_follow(2'b10, "R4");
        max_lo = 0.0;
        reg_write(8'h43);
        #800;
        check(max_lo <= 11.1, "R7", "pause on same-source select ns", $rtoi(max_lo), 11);
        check_follow(2'b11, "R4");

        // R8: second select written during a switch is held
        max_hi = 0.0;
        reg_write(8'h41);
        reg_write(8'h40);
        #2000;
        check(max_hi >= 29.9, "R8", "timer high phase ns seen", $rtoi(max_hi), 30);
        check_follow(2'b00, "R8");

        // Random write bursts with short gaps (R2, R4)
        model = 8'h40;
        for (int it = 0; it < 40; it++) begin
            model = 8'($urandom);
            reg_write(model);
            check_rd(exp_rd(model, 1'b1, 1'b1), "R2");
            repeat ($urandom_range(0, 30)) @(negedge reg_clk);
        end
        #2500;
        check_follow(model[1:0], "R4");

        // R5 / R6: no runt phases over the whole run
        check(min_hi >= 6.9, "R6", "shortest high ns", $rtoi(min_hi), 7);
        check(min_lo >= 6.9, "R6", "shortest low ns", $rtoi(min_lo), 7);
        check(max_hi <= 30.1, "R5", "longest high ns", $rtoi(max_hi), 30);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule